// File: doc/BRIEF.md
# Trap Capability Register Write Legaliser

This block sits on the write port of two special capability registers that trap handling uses: the exception return capability and the trap entry capability. Software writes either one through a single shared port. The block does not raise a trap for a bad value. It repairs the value and records it: any property that would make the value unsafe to use as a code pointer clears the stored tag. For the trap entry register the low address bits never hold a mode. They are forced to zero.

An instruction fetch that fails a bounds check also writes the exception return register. It stores the faulting program counter, aligned to two bytes, with its tag cleared. This capture takes priority over a software write aimed at the same register in the same cycle. A software write to the trap entry register in that cycle still takes effect.

Each register holds a tag bit and an address, in flops with a synchronous active-high reset. The stored values appear one clock after the write.

Top module: `trap_wr_legaliser`

## Requirements
- R1: While `rst` is high at a clock edge, both registers become tag 0 and address 0.
- R2: In a cycle with `wr_en` low and `fetch_fault` low, neither register changes.
- R3: A write whose `wr_sealed` is 1 stores tag 0, in whichever register is selected.
- R4: A write whose `wr_exec` is 0 stores tag 0, in whichever register is selected.
- R5: A write to the exception register (`wr_sel` = 0) with address bit 0 set stores that bit as 0 and tag 0. Bits 31:1 are stored unchanged.
- R6: A write to the trap entry register (`wr_sel` = 1) with bit 1 or bit 0 of the address set stores both bits as 0 and tag 0. Bits 31:2 are stored unchanged. `tvec_addr[1:0]` is always 0, so no mode is ever encoded there.
- R7: A write that is unsealed, executable and aligned stores its address unchanged and its tag unchanged. Alignment means bit 0 clear for the exception register, and bits 1:0 clear for the trap entry register.
- R8: `wr_sel` = 0 targets the exception register and `wr_sel` = 1 the trap entry register. The register that is not selected keeps its value.
- R9: When `fetch_fault` is high, the exception register stores `fault_pc` with bit 0 cleared and tag 0. This happens whatever the write port carries. A write to the trap entry register in the same cycle still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Target register: 0 = exception, 1 = trap entry |
| wr_tag | input | 1 | Tag of the written capability |
| wr_sealed | input | 1 | Written capability is sealed |
| wr_exec | input | 1 | Written capability has execute permission |
| wr_addr | input | 32 | Address of the written capability |
| fetch_fault | input | 1 | Instruction fetch bounds fault |
| fault_pc | input | 32 | Program counter of the faulting fetch |
| epc_tag | output | 1 | Stored tag, exception register |
| epc_addr | output | 32 | Stored address, exception register |
| tvec_tag | output | 1 | Stored tag, trap entry register |
| tvec_addr | output | 32 | Stored address, trap entry register |

## Verification
The assertions assume that every control input is a known 0 or 1 at each clock edge. They also assume that the write fields are meaningful only when `wr_en` is high. The write port and the fault input can fire together, so the properties for the exception register exclude fault cycles from their antecedents.

The stimulus drives every input to a defined value on each falling edge. It mixes concurrent writes and faults on purpose. It biases addresses toward aligned values, so the tag-preserving path (R7) is hit often alongside the repaired ones.

// File: rtl/trap_wr_pkg.sv
package trap_wr_pkg;
  localparam int CAP_AW = 32;

  typedef enum logic {
    SEL_EPC  = 1'b0,
    SEL_TVEC = 1'b1
  } trap_sel_e;

  typedef struct packed {
    logic              tag;
    logic              sealed;
    logic              exec;
    logic [CAP_AW-1:0] addr;
  } cap_wr_t;

  typedef struct packed {
    logic              tag;
    logic [CAP_AW-1:0] addr;
  } cap_held_t;
endpackage

// File: rtl/trap_cap_fix.sv
module trap_cap_fix
  import trap_wr_pkg::*;
#(
  parameter int LOW_BITS = 1
) (
  input  cap_wr_t   cap_in,
  output cap_held_t cap_out
);
  localparam int HI_W = CAP_AW - LOW_BITS;

  logic low_dirty;
  logic unusable;

  always_comb begin
    low_dirty = |cap_in.addr[LOW_BITS-1:0];
    unusable  = cap_in.sealed | ~cap_in.exec | low_dirty;
    cap_out.addr = {cap_in.addr[CAP_AW-1:LOW_BITS], {LOW_BITS{1'b0}}};
    cap_out.tag  = cap_in.tag & ~unusable;
  end

  initial begin
    a_r6_low_bits_range: assert (LOW_BITS >= 1 && HI_W >= 1);
  end
endmodule

// File: rtl/trap_cap_slot.sv
module trap_cap_slot
  import trap_wr_pkg::*;
#(
  parameter int LOW_BITS = 1
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  cap_wr_t   wr_val,
  output cap_held_t held
);
  cap_held_t fixed;
  cap_held_t held_q;

  trap_cap_fix #(.LOW_BITS(LOW_BITS)) u_fix (
    .cap_in (wr_val),
    .cap_out(fixed)
  );

  always_ff @(posedge clk) begin
    if (rst)       held_q <= '0;
    else if (load) held_q <= fixed;
  end

  assign held = held_q;

  // R5 / R6: the low bits of a stored address are zero at every edge after reset
  a_r6_low_clear: assert property (@(posedge clk) disable iff (rst)
    held_q.addr[LOW_BITS-1:0] == '0);

  // R7: a clean value is kept as written
  a_r7_clean_kept: assert property (@(posedge clk) disable iff (rst)
    (load && !wr_val.sealed && wr_val.exec && wr_val.addr[LOW_BITS-1:0] == '0)
    |=> (held_q.addr == $past(wr_val.addr) && held_q.tag == $past(wr_val.tag)));

  // R2: without a load the slot holds its value
  a_r2_slot_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(held_q));
endmodule

// File: rtl/trap_wr_legaliser.sv
module trap_wr_legaliser
  import trap_wr_pkg::*;
#(
  parameter int ADDR_W    = CAP_AW,
  parameter int EPC_LOW   = 1,
  parameter int TVEC_LOW  = 2,
  parameter int N_SLOTS   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic              wr_tag,
  input  logic              wr_sealed,
  input  logic              wr_exec,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              fetch_fault,
  input  logic [ADDR_W-1:0] fault_pc,
  output logic              epc_tag,
  output logic [ADDR_W-1:0] epc_addr,
  output logic              tvec_tag,
  output logic [ADDR_W-1:0] tvec_addr
);
  cap_wr_t   sw_val;
  cap_wr_t   fault_val;
  cap_held_t held [N_SLOTS];

  always_comb begin
    sw_val.tag    = wr_tag;
    sw_val.sealed = wr_sealed;
    sw_val.exec   = wr_exec;
    sw_val.addr   = wr_addr;
    fault_val.tag    = 1'b0;
    fault_val.sealed = 1'b0;
    fault_val.exec   = 1'b1;
    fault_val.addr   = fault_pc;
  end

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    localparam int LOWB = (s == int'(SEL_EPC)) ? EPC_LOW : TVEC_LOW;
    logic    ld;
    cap_wr_t src;
    if (s == int'(SEL_EPC)) begin : g_epc
      assign ld  = fetch_fault | (wr_en && wr_sel == SEL_EPC);
      assign src = fetch_fault ? fault_val : sw_val;
    end else begin : g_tvec
      assign ld  = wr_en && wr_sel == SEL_TVEC;
      assign src = sw_val;
    end
    trap_cap_slot #(.LOW_BITS(LOWB)) u_slot (
      .clk   (clk),
      .rst   (rst),
      .load  (ld),
      .wr_val(src),
      .held  (held[s])
    );
  end

  assign epc_tag   = held[SEL_EPC].tag;
  assign epc_addr  = held[SEL_EPC].addr;
  assign tvec_tag  = held[SEL_TVEC].tag;
  assign tvec_addr = held[SEL_TVEC].addr;

  initial begin
    a_r8_two_slots: assert (N_SLOTS == 2 && ADDR_W == CAP_AW);
  end

  a_r1_reset: assert property (@(posedge clk)
    rst |=> (!epc_tag && epc_addr == '0 && !tvec_tag && tvec_addr == '0));

  a_r3_sealed_epc: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_sel && wr_sealed && !fetch_fault) |=> !epc_tag);

  a_r3_sealed_tvec: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel && wr_sealed) |=> !tvec_tag);

  a_r4_noexec_epc: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_sel && !wr_exec && !fetch_fault) |=> !epc_tag);

  a_r4_noexec_tvec: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel && !wr_exec) |=> !tvec_tag);

  a_r5_epc_odd: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_sel && wr_addr[0] && !fetch_fault)
    |=> (!epc_tag && epc_addr == {$past(wr_addr[ADDR_W-1:1]), 1'b0}));

  a_r6_tvec_mode_bits: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel && wr_addr[1:0] != 2'b00)
    |=> (!tvec_tag && tvec_addr == {$past(wr_addr[ADDR_W-1:2]), 2'b00}));

  a_r8_other_kept: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel && !fetch_fault) |=> ($stable(epc_addr) && $stable(epc_tag)));

  a_r9_fault_capture: assert property (@(posedge clk) disable iff (rst)
    fetch_fault |=> (!epc_tag && epc_addr == {$past(fault_pc[ADDR_W-1:1]), 1'b0}));
endmodule

// File: tb/trap_wr_legaliser_bench.sv
module trap_wr_legaliser_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, wr_sel, wr_tag, wr_sealed, wr_exec, fetch_fault;
  logic [31:0] wr_addr, fault_pc;
  logic        epc_tag, tvec_tag;
  logic [31:0] epc_addr, tvec_addr;

  int          n_vec = 0;
  int          n_bad = 0;
  logic        m_etag, m_ttag;
  logic [31:0] m_eaddr, m_taddr;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  trap_wr_legaliser u_trap_wr_legaliser (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_tag(wr_tag),
    .wr_sealed(wr_sealed), .wr_exec(wr_exec), .wr_addr(wr_addr),
    .fetch_fault(fetch_fault), .fault_pc(fault_pc),
    .epc_tag(epc_tag), .epc_addr(epc_addr),
    .tvec_tag(tvec_tag), .tvec_addr(tvec_addr)
  );

  function automatic logic exp_tag(logic t, logic s, logic x, logic bad);
    return t & ~s & x & ~bad;
  endfunction

  function automatic string label_of();
    if (rst)                               return "R1";
    if (fetch_fault)                       return "R9";
    if (!wr_en)                            return "R2";
    if (wr_sealed)                         return "R3";
    if (!wr_exec)                          return "R4";
    if (!wr_sel && wr_addr[0])             return "R5";
    if (wr_sel && wr_addr[1:0] != 2'b00)   return "R6";
    return "R7/R8";
  endfunction

  task automatic model_step();
    if (rst) begin
      m_etag = 0; m_eaddr = 0; m_ttag = 0; m_taddr = 0;
    end else begin
      if (fetch_fault) begin
        m_etag = 0; m_eaddr = {fault_pc[31:1], 1'b0};
      end else if (wr_en && !wr_sel) begin
        m_etag  = exp_tag(wr_tag, wr_sealed, wr_exec, wr_addr[0]);
        m_eaddr = {wr_addr[31:1], 1'b0};
      end
      if (wr_en && wr_sel) begin
        m_ttag  = exp_tag(wr_tag, wr_sealed, wr_exec, |wr_addr[1:0]);
        m_taddr = {wr_addr[31:2], 2'b00};
      end
    end
  endtask

  task automatic apply(logic r, logic en, logic sel, logic t, logic s, logic x,
                       logic [31:0] a, logic f, logic [31:0] pc);
    string lbl;
    rst = r; wr_en = en; wr_sel = sel; wr_tag = t; wr_sealed = s; wr_exec = x;
    wr_addr = a; fetch_fault = f; fault_pc = pc;
    lbl = label_of();
    @(posedge clk);
    model_step();
    @(negedge clk);
    n_vec++;
    if (epc_tag !== m_etag || epc_addr !== m_eaddr ||
        tvec_tag !== m_ttag || tvec_addr !== m_taddr) begin
      n_bad++;
      $display("FAIL %s: got epc %0b/%h tvec %0b/%h, expected epc %0b/%h tvec %0b/%h",
               lbl, epc_tag, epc_addr, tvec_tag, tvec_addr,
               m_etag, m_eaddr, m_ttag, m_taddr);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    void'($urandom(32'd1234));
    @(negedge clk);
    // R1 reset state
    apply(1, 1, 0, 1, 0, 1, 32'h1000_0000, 0, 0);
    // R7 clean writes keep tag and address
    apply(0, 1, 0, 1, 0, 1, 32'h2000_0102, 0, 0);
    apply(0, 1, 1, 1, 0, 1, 32'h3000_0100, 0, 0);
    // R2 idle cycle leaves both registers
    apply(0, 0, 1, 1, 1, 0, 32'hFFFF_FFFF, 0, 32'h5);
    // R3 sealed, R4 non-executable
    apply(0, 1, 0, 1, 1, 1, 32'h4000_0000, 0, 0);
    apply(0, 1, 1, 1, 0, 0, 32'h4000_0010, 0, 0);
    // R5 odd exception address; R6 each low bit of trap entry
    apply(0, 1, 0, 1, 0, 1, 32'h5000_0003, 0, 0);
    apply(0, 1, 1, 1, 0, 1, 32'h6000_0001, 0, 0);
    apply(0, 1, 1, 1, 0, 1, 32'h6000_0002, 0, 0);
    // R8 trap entry write leaves exception register
    apply(0, 1, 1, 1, 0, 1, 32'h7000_0004, 0, 0);
    // R9 fault beats exception write; concurrent trap entry write kept
    apply(0, 1, 0, 1, 0, 1, 32'h8000_0000, 1, 32'h9000_0007);
    apply(0, 1, 1, 1, 0, 1, 32'hA000_0008, 1, 32'hB000_0002);
    // R1 reset again after activity
    apply(1, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      a = $urandom;
      if ($urandom_range(1, 0) == 0) a[1:0] = 2'b00;
      apply(($urandom_range(99, 0) == 0), ($urandom_range(9, 0) < 7),
            $urandom_range(1, 0), $urandom_range(1, 0),
            ($urandom_range(3, 0) == 0), ($urandom_range(3, 0) != 0),
            a, ($urandom_range(9, 0) == 0), $urandom);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule